// File: doc/BRIEF.md
# UART Receiver with Break and Error Flags

This block turns an asynchronous serial line into characters of 5 to 8 bits. It samples the line on a 16x oversampling enable, confirms each start bit at its centre, and then reads the data bits, LSB first, one bit period apart. An optional parity bit follows the data, and a single stop-bit sample comes after that. Each finished character goes into a small receive FIFO together with three tags: framing error, parity error and break.

Software or a bus wrapper reads the FIFO through a pop strobe. It sees the head character on `rd_data` and an 8-bit status byte. The status byte carries the tags of the head entry, a sticky overrun flag, FIFO full, and receive-ready. The two transmitter bits are held at zero.

A break is a character whose data bits are all zero and whose stop bit is low. It places exactly one entry in the FIFO. The receiver then ignores the line until the line has stayed high for half a bit period.

Top module: `uart_rx_status`

## Requirements
- R1: After reset, `status` is 8'h00 and `rd_data` is 0. Status bit positions are: 7 break, 6 framing error, 5 parity error, 4 overrun, 3 transmitter empty (always 0), 2 transmitter ready (always 0), 1 FIFO full, 0 receive-ready.
- R2: A low level starts a character only if the line is still low at the 8th 16x tick after the low level was first seen. A shorter low pulse creates no FIFO entry.
- R3: Data bits are taken LSB first, one every 16 ticks after the start-centre sample. `char_len` selects the length: 00 = 5, 01 = 6, 10 = 7, 11 = 8 bits. `rd_data` is right-aligned and its unused upper bits are zero.
- R4: When `par_en` = 1, one parity bit follows the data. `par_odd` = 1 selects odd parity and 0 selects even parity. A mismatch sets status bit 5 for that entry.
- R5: The stop bit is sampled once, one bit period after the last data bit, or after the parity bit when parity is enabled. A low sample stores the character with status bit 6 set.
- R6: A character whose data bits are all zero, whose parity bit (if enabled) is zero, and whose stop sample is low is stored as one break entry. That entry has data 0, bit 7 = 1, bit 6 = 1 and bit 5 = 0.
- R7: After a break, no entry is written until the line has been high for 8 consecutive 16x ticks. A shorter high interval restarts this wait.
- R8: A line that drops low in the middle of a character and stays low produces two entries. The first is the interrupted character with a framing error. The second is one break entry.
- R9: Status bit 0 is high while the FIFO holds at least one entry. Status bit 1 is high while every position is occupied. A pulse on `rd_pop` removes the head. Bits 7..5 and `rd_data` describe the head entry and read 0 when the FIFO is empty.
- R10: A character that completes while the FIFO is full is discarded and sets status bit 4. Bit 4 stays set until `err_clr` is pulsed, and it reads 0 in the cycle after that pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick16 | input | 1 | One-cycle enable, 16 per bit period |
| rxd | input | 1 | Serial input, idle high |
| char_len | input | 2 | Character length code |
| par_en | input | 1 | Parity bit present |
| par_odd | input | 1 | 1 = odd parity, 0 = even parity |
| rd_pop | input | 1 | Remove the FIFO head |
| err_clr | input | 1 | Clear the overrun flag |
| rd_data | output | 8 | Head character |
| status | output | 8 | Status byte |

## Verification
The bench builds the block with the default 4-entry FIFO, 16x oversampling and a two-stage input synchronizer. A depth of four lets five back-to-back characters reach the overrun path quickly, and it also exercises the power-of-two pointer wrap. The 16x enable fires every fourth clock, so a bit lasts 64 clocks. That spacing leaves several clocks of margin at each centre sample, so the bench can test a stop bit that ends low, a false start right after it, and a high gap of two ticks inside the break hold-off.

// File: rtl/srx_pkg.sv
package srx_pkg;

   typedef struct packed {
      logic       rb;
      logic       fe;
      logic       pe;
      logic [7:0] data;
   } srx_entry_t;

   typedef enum logic [2:0] {
      S_IDLE, S_START, S_DATA, S_PAR, S_STOP, S_BRKW
   } srx_state_t;

   function automatic logic [3:0] char_bits(input logic [1:0] code);
      return 4'd5 + {2'b00, code};
   endfunction

endpackage

// File: rtl/srx_deser.sv
module srx_deser
   import srx_pkg::*;
#(
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick,
   input  logic       rxd,
   input  logic [1:0] char_len,
   input  logic       par_en,
   input  logic       par_odd,
   output logic       done,
   output srx_entry_t res
);
   localparam int HALF = OSR / 2;
   localparam int CW   = $clog2(OSR);

   logic rx;

   generate
      if (SYNC_STAGES == 0) begin : g_nosync
         assign rx = rxd;
      end else begin : g_sync
         logic [SYNC_STAGES-1:0] sr;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) sr <= '1;
            else        sr <= {sr[SYNC_STAGES-2:0], rxd};
         end
         assign rx = sr[SYNC_STAGES-1];
      end
   endgenerate

   srx_state_t  st;
   logic [CW-1:0] cnt;
   logic [2:0]  bidx;
   logic [7:0]  sh;
   logic        pbit;
   logic [3:0]  nbits;
   logic [7:0]  aligned;
   logic        allzero;

   assign nbits   = char_bits(char_len);
   assign aligned = sh >> (4'd8 - nbits);
   assign allzero = (aligned == 8'd0) && (!par_en || !pbit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st   <= S_IDLE;
         cnt  <= '0;
         bidx <= '0;
         sh   <= '0;
         pbit <= 1'b0;
         done <= 1'b0;
         res  <= '0;
      end else begin
         done <= 1'b0;
         if (tick) begin
            case (st)
               S_IDLE: if (!rx) begin
                  st  <= S_START;
                  cnt <= '0;
               end
               S_START: if (cnt == CW'(HALF - 1)) begin
                  cnt <= '0;
                  if (!rx) begin
                     st   <= S_DATA;
                     bidx <= '0;
                     sh   <= '0;
                     pbit <= 1'b0;
                  end else begin
                     st <= S_IDLE;
                  end
               end else cnt <= cnt + 1'b1;
               S_DATA: if (cnt == CW'(OSR - 1)) begin
                  cnt  <= '0;
                  sh   <= {rx, sh[7:1]};
                  bidx <= bidx + 1'b1;
                  if ({1'b0, bidx} == nbits - 4'd1) st <= par_en ? S_PAR : S_STOP;
               end else cnt <= cnt + 1'b1;
               S_PAR: if (cnt == CW'(OSR - 1)) begin
                  cnt  <= '0;
                  pbit <= rx;
                  st   <= S_STOP;
               end else cnt <= cnt + 1'b1;
               S_STOP: if (cnt == CW'(OSR - 1)) begin
                  cnt  <= '0;
                  done <= 1'b1;
                  if (!rx && allzero) begin
                     res <= '{rb: 1'b1, fe: 1'b1, pe: 1'b0, data: 8'd0};
                     st  <= S_BRKW;
                  end else begin
                     res <= '{rb: 1'b0, fe: !rx,
                              pe: par_en & (^aligned ^ pbit ^ par_odd),
                              data: aligned};
                     st  <= S_IDLE;
                  end
               end else cnt <= cnt + 1'b1;
               S_BRKW: if (!rx) cnt <= '0;
               else if (cnt == CW'(HALF - 1)) begin
                  cnt <= '0;
                  st  <= S_IDLE;
               end else cnt <= cnt + 1'b1;
               default: st <= S_IDLE;
            endcase
         end
      end
   end

endmodule

// File: rtl/srx_fifo.sv
module srx_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 11
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         push,
   input  logic [W-1:0] wdata,
   input  logic         pop,
   output logic [W-1:0] rdata,
   output logic         empty,
   output logic         full
);
   localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam int CW = $clog2(DEPTH + 1);

   logic [W-1:0]  mem [DEPTH];
   logic [PW-1:0] wp, rp, wp_n, rp_n;
   logic [CW-1:0] cnt;

   generate
      if ((DEPTH & (DEPTH - 1)) == 0) begin : g_pow2
         assign wp_n = wp + 1'b1;
         assign rp_n = rp + 1'b1;
      end else begin : g_wrap
         assign wp_n = (wp == PW'(DEPTH - 1)) ? '0 : wp + 1'b1;
         assign rp_n = (rp == PW'(DEPTH - 1)) ? '0 : rp + 1'b1;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (push) mem[wp] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wp  <= '0;
         rp  <= '0;
         cnt <= '0;
      end else begin
         if (push) wp <= wp_n;
         if (pop)  rp <= rp_n;
         case ({push, pop})
            2'b10:   cnt <= cnt + 1'b1;
            2'b01:   cnt <= cnt - 1'b1;
            default: cnt <= cnt;
         endcase
      end
   end

   assign rdata = mem[rp];
   assign empty = (cnt == '0);
   assign full  = (cnt == CW'(DEPTH));

endmodule

// File: rtl/uart_rx_status.sv
module uart_rx_status
   import srx_pkg::*;
#(
   parameter int DEPTH       = 4,
   parameter int OSR         = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick16,
   input  logic       rxd,
   input  logic [1:0] char_len,
   input  logic       par_en,
   input  logic       par_odd,
   input  logic       rd_pop,
   input  logic       err_clr,
   output logic [7:0] rd_data,
   output logic [7:0] status
);
   localparam int EW = $bits(srx_entry_t);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("DEPTH must be at least 2");
      end
      if (OSR < 4 || (OSR % 2) != 0) begin : g_bad_osr
         $error("OSR must be even and at least 4");
      end
      if (SYNC_STAGES < 0 || SYNC_STAGES > 3) begin : g_bad_sync
         $error("SYNC_STAGES must lie in 0..3");
      end
   endgenerate

   logic          done;
   srx_entry_t    res, head;
   logic [EW-1:0] fifo_q;
   logic          empty, full, push, pop, rdy, oe;

   srx_deser #(.OSR(OSR), .SYNC_STAGES(SYNC_STAGES)) u_deser (
      .clk(clk), .rst_n(rst_n), .tick(tick16), .rxd(rxd),
      .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
      .done(done), .res(res)
   );

   assign push = done & ~full;
   assign pop  = rd_pop & ~empty;

   srx_fifo #(.DEPTH(DEPTH), .W(EW)) u_fifo (
      .clk(clk), .rst_n(rst_n), .push(push), .wdata(res),
      .pop(pop), .rdata(fifo_q), .empty(empty), .full(full)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)              oe <= 1'b0;
      else if (err_clr)        oe <= 1'b0;
      else if (done && full)   oe <= 1'b1;
   end

   assign head    = srx_entry_t'(fifo_q);
   assign rdy     = ~empty;
   assign rd_data = rdy ? head.data : 8'd0;
   assign status  = {head.rb & rdy, head.fe & rdy, head.pe & rdy, oe,
                     1'b0, 1'b0, full, rdy};

endmodule

// File: rtl/srx_chk.sv
module srx_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       err_clr,
   input logic [7:0] rd_data,
   input logic [7:0] status
);
   assert_full_has_data_R9: assert property (@(posedge clk) disable iff (!rst_n)
      status[1] |-> status[0]);

   assert_empty_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !status[0] |-> (status[7:5] == 3'b000 && rd_data == 8'd0));

   assert_break_shape_R6: assert property (@(posedge clk) disable iff (!rst_n)
      status[7] |-> (status[6] && !status[5] && rd_data == 8'd0));

   assert_oe_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (status[4] && !err_clr) |=> status[4]);

   assert_oe_clear_R10: assert property (@(posedge clk) disable iff (!rst_n)
      err_clr |=> !status[4]);

   assert_oe_needs_full_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(status[4]) |-> $past(status[1]));
endmodule

bind uart_rx_status srx_chk u_chk (
   .clk(clk), .rst_n(rst_n), .err_clr(err_clr),
   .rd_data(rd_data), .status(status)
);

// File: tb/sim_uart_rx_status.sv
`timescale 1ns/100ps
module sim_uart_rx_status;
   localparam int DEPTH = 4;
   localparam int OSR   = 16;
   localparam int BT    = OSR * 4;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick16 = 1'b0;
   logic       rxd = 1'b1;
   logic [1:0] char_len = 2'b11;
   logic       par_en = 1'b0;
   logic       par_odd = 1'b0;
   logic       rd_pop = 1'b0;
   logic       err_clr = 1'b0;
   logic [7:0] rd_data, status;

   int errs = 0;
   int checks = 0;
   bit pop_en = 1'b0;
   logic [1:0] tdiv = '0;
   logic [10:0] exp_q[$];
   string       tag_q[$];

   always #2.5 clk = ~clk;

   always @(negedge clk) begin
      tdiv   <= tdiv + 1'b1;
      tick16 <= (tdiv == 2'd3);
   end

   uart_rx_status #(.DEPTH(DEPTH), .OSR(OSR), .SYNC_STAGES(2)) u0 (
      .clk(clk), .rst_n(rst_n), .tick16(tick16), .rxd(rxd),
      .char_len(char_len), .par_en(par_en), .par_odd(par_odd),
      .rd_pop(rd_pop), .err_clr(err_clr), .rd_data(rd_data), .status(status)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic summary();
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   endtask

   // monitor: pops the design FIFO and compares against the scoreboard
   initial begin
      forever begin
         @(negedge clk);
         if (rd_pop) rd_pop = 1'b0;
         else if (pop_en && status[0]) begin
            if (exp_q.size() == 0) begin
               check("R9 unexpected entry", {21'd0, status[7:5], rd_data}, 32'hFFFF_FFFF);
            end else begin
               logic [10:0] e;
               string t;
               e = exp_q.pop_front();
               t = tag_q.pop_front();
               check(t, {21'd0, status[7:5], rd_data}, {21'd0, e});
            end
            rd_pop = 1'b1;
         end
      end
   end

   initial begin
      repeat (200000) @(posedge clk);
      errs++;
      checks++;
      $display("FAIL R9 watchdog actual=running expected=finished");
      summary();
   end

   task automatic drive(input logic v, input int bits);
      rxd = v;
      repeat (bits * BT) @(negedge clk);
   endtask

   task automatic expect_entry(input logic rb, input logic fe, input logic pe,
                               input logic [7:0] d, input string tag);
      exp_q.push_back({rb, fe, pe, d});
      tag_q.push_back(tag);
   endtask

   task automatic send_char(input logic [7:0] d, input int nb, input bit pen,
                            input bit odd, input bit badp, input bit stopl,
                            input bit store, input string tag);
      logic [7:0] dm;
      logic pb;
      dm = d & 8'((1 << nb) - 1);
      pb = (^dm) ^ odd ^ badp;
      char_len = 2'(nb - 5);
      par_en   = pen;
      par_odd  = odd;
      if (store) expect_entry(1'b0, !stopl, badp & pen, dm, tag);
      drive(1'b0, 1);
      for (int i = 0; i < nb; i++) drive(dm[i], 1);
      if (pen) drive(pb, 1);
      drive(stopl, 1);
      drive(1'b1, 2);
   endtask

   task automatic drain(input string tag);
      for (int i = 0; i < 20000 && (exp_q.size() != 0 || status[0]); i++) @(negedge clk);
      repeat (4) @(negedge clk);
      check(tag, exp_q.size(), 0);
   endtask

   initial begin
      repeat (5) @(negedge clk);
      check("R1 reset status", status, 8'h00);
      check("R1 reset data", rd_data, 8'h00);
      rst_n = 1'b1;
      repeat (5) @(negedge clk);
      pop_en = 1'b1;

      // R2: short low glitch gives no entry
      rxd = 1'b0;
      repeat (12) @(negedge clk);
      rxd = 1'b1;
      repeat (3 * BT) @(negedge clk);
      check("R2 glitch rejected", status[0], 1'b0);

      // R3: lengths, LSB first
      send_char(8'hA5, 8, 0, 0, 0, 1, 1, "R3 8-bit");
      send_char(8'hF3, 5, 0, 0, 0, 1, 1, "R3 5-bit masked");
      send_char(8'h2D, 6, 0, 0, 0, 1, 1, "R3 6-bit");
      // R4: parity
      send_char(8'h51, 7, 1, 0, 0, 1, 1, "R4 even ok");
      send_char(8'h51, 7, 1, 0, 1, 1, 1, "R4 even bad");
      send_char(8'h13, 6, 1, 1, 0, 1, 1, "R4 odd ok");
      send_char(8'h13, 6, 1, 1, 1, 1, 1, "R4 odd bad");
      // R5: framing error with stop low, then false start rejected
      send_char(8'h3C, 8, 0, 0, 0, 0, 1, "R5 framing");
      send_char(8'h0F, 8, 1, 0, 0, 0, 1, "R5 framing parity");
      drain("R5 drained");

      // R6/R7: break, short high gap inside hold-off, then recovery
      char_len = 2'b11; par_en = 1'b0;
      expect_entry(1'b1, 1'b1, 1'b0, 8'h00, "R6 break entry");
      drive(1'b0, 12);
      rxd = 1'b1;
      repeat (8) @(negedge clk);
      drive(1'b0, 3);
      drive(1'b1, 3);
      drain("R7 single entry during hold-off");
      send_char(8'h5A, 8, 0, 0, 0, 1, 1, "R7 recovered");
      drain("R7 drained");

      // R8: break starting mid-character
      expect_entry(1'b0, 1'b1, 1'b0, 8'h01, "R8 interrupted char");
      expect_entry(1'b1, 1'b1, 1'b0, 8'h00, "R8 break after");
      drive(1'b0, 1);
      drive(1'b1, 1);
      drive(1'b0, 20);
      drive(1'b1, 3);
      drain("R8 drained");
      check("R9 empty status", status, 8'h00);

      // R10: overrun
      pop_en = 1'b0;
      send_char(8'h11, 8, 0, 0, 0, 1, 1, "R10 kept 1");
      send_char(8'h22, 8, 0, 0, 0, 1, 1, "R10 kept 2");
      send_char(8'h33, 8, 0, 0, 0, 1, 1, "R10 kept 3");
      send_char(8'h44, 8, 0, 0, 0, 1, 1, "R10 kept 4");
      check("R9 full flag", status[1:0], 2'b11);
      check("R10 no overrun yet", status[4], 1'b0);
      send_char(8'h55, 8, 0, 0, 0, 1, 0, "R10 dropped");
      check("R10 overrun set", status[4], 1'b1);
      drive(1'b1, 2);
      check("R10 overrun sticky", status[4], 1'b1);
      check("R9 head data", rd_data, 8'h11);
      err_clr = 1'b1;
      @(negedge clk);
      err_clr = 1'b0;
      check("R10 overrun cleared", status[4], 1'b0);
      pop_en = 1'b1;
      drain("R10 drained");
      check("R9 final status", status, 8'h00);
      summary();
   end
endmodule